// File: doc/BRIEF.md
# CAN Frame Acceptance Filter

This block decides, for each received CAN frame, whether the frame should be kept for the host. A frame parser upstream presents the identifier, the extended-format flag, the remote-request bit, the data length code and the first two data bytes, together with a one-cycle strobe. The block compares selected bits of these fields against four programmable code bytes. Four matching mask bytes mark which bits take part in the comparison. One clock after the strobe, the block presents a registered accept flag.

Three filter arrangements are selectable through two mode pins:
- **Legacy mode** uses only code byte 0 and mask byte 0. They are compared against the eight most significant identifier bits.
- **Enhanced single mode** uses all four byte pairs as one long filter.
- **Enhanced dual mode** splits the four byte pairs into two shorter filters. The frame is kept when either filter matches.

The bits taken from the frame depend on the frame format. Data bytes that a frame does not carry never cause a rejection. Code and mask bytes can be written only while the configuration-hold input is high.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, accept is 0, all code bytes are 0x00 and all mask bytes are 0xFF, so the first frame strobed with no writes is accepted.
- R2: A register write (cfg_we) changes nothing unless cfg_hold is high in the same cycle. Addresses 0 to 3 select code bytes 0 to 3, and addresses 4 to 7 select mask bytes 0 to 3.
- R3: A mask bit of 0 makes the paired bit relevant and a mask bit of 1 makes it don't-care. A filter matches only when every relevant frame bit equals its code bit.
- R4: Legacy mode (enh_mode=0) compares code byte 0 and mask byte 0 with ID[10:3] for a standard frame and with ID[28:21] for an extended frame.
- R5: Single mode (enh_mode=1, dual_flt=0) for a standard frame compares the following, and bits 3:0 of byte 1 are don't-care:
  - byte 0 with ID[10:3];
  - byte 1 bits 7:5 with ID[2:0];
  - byte 1 bit 4 with RTR;
  - byte 2 with data byte 0;
  - byte 3 with data byte 1.
- R6: Single mode for an extended frame compares the following, and bits 1:0 of byte 3 are don't-care:
  - the 32-bit code {byte0,byte1,byte2,byte3} bits 31:3 with ID[28:0];
  - bit 2 with RTR.
- R7: Dual mode (enh_mode=1, dual_flt=1) for a standard frame builds two filters and accepts when either matches:
  - Filter 1: byte 0 with ID[10:3], byte 1 with {ID[2:0], RTR, data0[7:4]}, and byte 3 bits 3:0 with data0[3:0].
  - Filter 2: byte 2 with ID[10:3], and byte 3 bits 7:4 with {ID[2:0], RTR}.
- R8: Dual mode for an extended frame compares bytes 0 and 1 (filter 1) and bytes 2 and 3 (filter 2), each pair with ID[28:13], and accepts when either matches.
- R9: A data byte the frame does not carry never causes a rejection. Data byte 0 is absent when RTR=1 or DLC=0. Data byte 1 is absent when RTR=1 or DLC<2.
- R10: accept takes its new value on the clock edge at which frm_valid is high, and keeps that value while frm_valid stays low.
- R11: A frame strobed in the same cycle as an allowed register write is judged against the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_hold | input | 1 | Configuration hold; register writes are allowed only while high |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register select: 0-3 code bytes, 4-7 mask bytes |
| cfg_wdata | input | 8 | Register write data |
| enh_mode | input | 1 | 0 selects legacy mode, 1 selects enhanced mode |
| dual_flt | input | 1 | In enhanced mode, 1 selects two filters and 0 selects one long filter |
| frm_valid | input | 1 | One-cycle strobe marking valid frame fields |
| frm_id | input | 29 | Identifier; a standard frame uses bits 10:0 |
| frm_ext | input | 1 | 1 for an extended-format frame |
| frm_rtr | input | 1 | Remote-request bit |
| frm_dlc | input | 4 | Data length code |
| frm_data0 | input | 8 | First data byte |
| frm_data1 | input | 8 | Second data byte |
| accept | output | 1 | Registered verdict for the last strobed frame |

## Verification
A write to a code byte and a frame strobe can arrive in the same cycle, and the design must judge the frame by the old contents. The bench loads code byte 0 to match a frame, then in one cycle both clears that byte and strobes the matching frame, expecting accept=1. It then strobes the same frame again and expects accept=0, which shows that the write did land for the following frame.

// File: rtl/can_af_pkg.sv
// Package for the acceptance filter: widths and the filter-arrangement type.
// Assumes four code/mask byte pairs and a 29-bit identifier field.
package can_af_pkg;
    localparam int AF_BYTES = 4;
    localparam int AF_BW    = 8;
    localparam int AF_VW    = AF_BYTES * AF_BW;
    localparam int AF_IDW   = 29;
    localparam int AF_NFLT  = 2;

    typedef enum logic [1:0] {
        FM_LEGACY = 2'd0,
        FM_SINGLE = 2'd1,
        FM_DUAL   = 2'd2
    } fmode_e;

    typedef logic [AF_VW-1:0] afvec_t;
endpackage

// File: rtl/can_af_regs.sv
// Code and mask byte registers. Writes land only while cfg_hold is high.
// Flat outputs place byte 0 in the most significant position.
// Assumes 2*BYTES addresses; the top address bit selects the mask bank.
module can_af_regs #(
    parameter int BYTES = 4,
    parameter int BW    = 8,
    localparam int AW    = $clog2(2 * BYTES),
    localparam int IDX_W = AW - 1,
    localparam int VW    = BYTES * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_hold,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [BW-1:0] cfg_wdata,
    output logic [VW-1:0] code_flat,
    output logic [VW-1:0] mask_flat
);
    logic wr_ok;
    assign wr_ok = cfg_hold && cfg_we;

    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        localparam int POS = (BYTES - 1 - i) * BW;

        // Code byte i: reset to all zeros, loaded on a permitted write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                code_flat[POS +: BW] <= '0;
            else if (wr_ok && !cfg_addr[AW-1] && cfg_addr[IDX_W-1:0] == IDX_W'(i))
                code_flat[POS +: BW] <= cfg_wdata;
        end

        // Mask byte i: reset to all ones (everything don't-care).
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_flat[POS +: BW] <= '1;
            else if (wr_ok && cfg_addr[AW-1] && cfg_addr[IDX_W-1:0] == IDX_W'(i))
                mask_flat[POS +: BW] <= cfg_wdata;
        end
    end

    // R2
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_hold |=> ($stable(code_flat) && $stable(mask_flat)));
endmodule

// File: rtl/can_af_map.sv
// Field mapper: arranges frame fields into the 32-bit layout of the code
// register for each filter. Also marks bits excluded from each filter
// (unused positions, missing data bytes). Purely combinational.
module can_af_map
    import can_af_pkg::*;
(
    input  fmode_e            fmode,
    input  logic [AF_IDW-1:0] id,
    input  logic              ext,
    input  logic              rtr,
    input  logic [3:0]        dlc,
    input  logic [AF_BW-1:0]  d0,
    input  logic [AF_BW-1:0]  d1,
    output afvec_t            rx_a,
    output afvec_t            ign_a,
    output afvec_t            rx_b,
    output afvec_t            ign_b,
    output logic              use_b
);
    logic miss0, miss1;
    logic [AF_BW-1:0] ign_d0, ign_d1;

    // Data bytes absent from the frame are excluded from comparison.
    always_comb begin
        miss0  = rtr || (dlc == 4'd0);
        miss1  = rtr || (dlc < 4'd2);
        ign_d0 = miss0 ? '1 : '0;
        ign_d1 = miss1 ? '1 : '0;
    end

    // Select the bit layout for the current arrangement and frame format.
    always_comb begin
        rx_a  = '0;
        ign_a = '1;
        rx_b  = '0;
        ign_b = '1;
        use_b = 1'b0;
        unique case (fmode)
            FM_LEGACY: begin
                rx_a  = {(ext ? id[28:21] : id[10:3]), 24'h0};
                ign_a = {8'h00, 24'hFF_FFFF};
            end
            FM_SINGLE: begin
                if (ext) begin
                    rx_a  = {id[28:0], rtr, 2'b00};
                    ign_a = 32'h0000_0003;
                end else begin
                    rx_a  = {id[10:0], rtr, 4'h0, d0, d1};
                    ign_a = {12'h000, 4'hF, ign_d0, ign_d1};
                end
            end
            FM_DUAL: begin
                use_b = 1'b1;
                if (ext) begin
                    rx_a  = {id[28:13], 16'h0000};
                    ign_a = 32'h0000_FFFF;
                    rx_b  = {16'h0000, id[28:13]};
                    ign_b = 32'hFFFF_0000;
                end else begin
                    rx_a  = {id[10:0], rtr, d0[7:4], 8'h00, 4'h0, d0[3:0]};
                    ign_a = {12'h000, ign_d0[7:4], 8'hFF, 4'hF, ign_d0[3:0]};
                    rx_b  = {16'h0000, id[10:0], rtr, 4'h0};
                    ign_b = {16'hFFFF, 12'h000, 4'hF};
                end
            end
            default: begin
                rx_a  = '0;
                ign_a = '1;
            end
        endcase
    end
endmodule

// File: rtl/can_af_match.sv
// Bitwise matcher: a hit means every bit that is neither masked nor
// excluded equals the code bit. One instance per filter.
module can_af_match #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] code,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] rx,
    input  logic [W-1:0] ign,
    output logic         hit
);
    // Reduce the per-bit agreement vector to one hit flag.
    always_comb hit = &(~(rx ^ code) | mask | ign);

    // R3
    open_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask | ign) == '1) |-> hit);
endmodule

// File: rtl/can_accept_filter.sv
// Top-level acceptance filter. It combines the register bank, the field
// mapper and two matchers. The verdict is registered on the frame strobe.
// Assumes frame fields are stable in the strobe cycle.
module can_accept_filter
    import can_af_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_hold,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              enh_mode,
    input  logic              dual_flt,
    input  logic              frm_valid,
    input  logic [28:0]       frm_id,
    input  logic              frm_ext,
    input  logic              frm_rtr,
    input  logic [3:0]        frm_dlc,
    input  logic [7:0]        frm_data0,
    input  logic [7:0]        frm_data1,
    output logic              accept
);
    afvec_t code_flat, mask_flat;
    afvec_t rx_v  [AF_NFLT];
    afvec_t ign_v [AF_NFLT];
    logic [AF_NFLT-1:0] hit;
    logic   use_b, verdict;
    fmode_e fmode;

    // Decode the two mode pins into a filter arrangement.
    always_comb fmode = !enh_mode ? FM_LEGACY : (dual_flt ? FM_DUAL : FM_SINGLE);

    can_af_regs #(.BYTES(AF_BYTES), .BW(AF_BW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .code_flat(code_flat), .mask_flat(mask_flat)
    );

    can_af_map u_map (
        .fmode(fmode), .id(frm_id), .ext(frm_ext), .rtr(frm_rtr), .dlc(frm_dlc),
        .d0(frm_data0), .d1(frm_data1),
        .rx_a(rx_v[0]), .ign_a(ign_v[0]), .rx_b(rx_v[1]), .ign_b(ign_v[1]),
        .use_b(use_b)
    );

    for (genvar f = 0; f < AF_NFLT; f++) begin : g_flt
        can_af_match #(.W(AF_VW)) u_match (
            .clk(clk), .rst_n(rst_n), .code(code_flat), .mask(mask_flat),
            .rx(rx_v[f]), .ign(ign_v[f]), .hit(hit[f])
        );
    end

    // The second filter counts only in dual arrangement.
    always_comb verdict = hit[0] || (use_b && hit[1]);

    // Capture the verdict on the strobe and hold it until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            accept <= 1'b0;
        else if (frm_valid)
            accept <= verdict;
    end

    // R10
    accept_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> $stable(accept));

    // R10
    accept_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accept) |-> $past(frm_valid));
endmodule

// File: tb/sim_can_accept_filter.sv
`timescale 1ns/1ps
module sim_can_accept_filter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_hold = 1'b0, cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic enh_mode = 1'b0, dual_flt = 1'b0, frm_valid = 1'b0;
    logic [28:0] frm_id = '0;
    logic frm_ext = 1'b0, frm_rtr = 1'b0;
    logic [3:0] frm_dlc = '0;
    logic [7:0] frm_data0 = '0, frm_data1 = '0;
    logic accept;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    can_accept_filter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .enh_mode(enh_mode),
        .dual_flt(dual_flt), .frm_valid(frm_valid), .frm_id(frm_id),
        .frm_ext(frm_ext), .frm_rtr(frm_rtr), .frm_dlc(frm_dlc),
        .frm_data0(frm_data0), .frm_data1(frm_data1), .accept(accept)
    );

    typedef struct packed {
        logic [31:0] code;
        logic [31:0] mask;
        logic        enh;
        logic        dual;
        logic [28:0] id;
        logic        ext;
        logic        rtr;
        logic [3:0]  dlc;
        logic [7:0]  d0;
        logic [7:0]  d1;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        // R4 legacy, standard, top identifier byte matches / differs
        '{32'hA500_0000, 32'h00FF_FFFF, 1'b0, 1'b0, 29'h52F, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00, 1'b1, 4'd4},
        '{32'hA500_0000, 32'h00FF_FFFF, 1'b0, 1'b0, 29'h4AF, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00, 1'b0, 4'd4},
        // R4 legacy, extended uses ID[28:21]
        '{32'h3C00_0000, 32'h00FF_FFFF, 1'b0, 1'b0, 29'h0780_1234, 1'b1, 1'b0, 4'd8, 8'h00, 8'h00, 1'b1, 4'd4},
        // R5 single standard with data bytes
        '{32'h2460_1122, 32'h000F_0000, 1'b1, 1'b0, 29'h123, 1'b0, 1'b0, 4'd2, 8'h11, 8'h22, 1'b1, 4'd5},
        '{32'h2460_1122, 32'h000F_0000, 1'b1, 1'b0, 29'h123, 1'b0, 1'b0, 4'd2, 8'h11, 8'h23, 1'b0, 4'd5},
        // R9 second data byte absent (DLC=1)
        '{32'h2460_1122, 32'h000F_0000, 1'b1, 1'b0, 29'h123, 1'b0, 1'b0, 4'd1, 8'h11, 8'h99, 1'b1, 4'd9},
        // R9 remote frame, both data bytes absent
        '{32'h2470_1122, 32'h0000_0000, 1'b1, 1'b0, 29'h123, 1'b0, 1'b1, 4'd0, 8'h55, 8'h55, 1'b1, 4'd9},
        // R5 RTR bit compared
        '{32'h2470_1122, 32'h0000_0000, 1'b1, 1'b0, 29'h123, 1'b0, 1'b0, 4'd0, 8'h55, 8'h55, 1'b0, 4'd5},
        // R6 single extended
        '{32'h91A2_B3C0, 32'h0000_0003, 1'b1, 1'b0, 29'h1234_5678, 1'b1, 1'b0, 4'd0, 8'h00, 8'h00, 1'b1, 4'd6},
        '{32'h91A2_B3C0, 32'h0000_0003, 1'b1, 1'b0, 29'h1234_5679, 1'b1, 1'b0, 4'd0, 8'h00, 8'h00, 1'b0, 4'd6},
        // R7 dual standard: filter 1, filter 2, neither
        '{32'h246A_FFFB, 32'h0000_0000, 1'b1, 1'b1, 29'h123, 1'b0, 1'b0, 4'd1, 8'hAB, 8'h00, 1'b1, 4'd7},
        '{32'h246A_FFFB, 32'h0000_0000, 1'b1, 1'b1, 29'h7FF, 1'b0, 1'b1, 4'd0, 8'h00, 8'h00, 1'b1, 4'd7},
        '{32'h246A_FFFB, 32'h0000_0000, 1'b1, 1'b1, 29'h7FF, 1'b0, 1'b0, 4'd1, 8'hAB, 8'h00, 1'b0, 4'd7},
        // R8 dual extended: filter 2, filter 1, neither
        '{32'h0000_91A2, 32'h0000_0000, 1'b1, 1'b1, 29'h1234_5678, 1'b1, 1'b0, 4'd0, 8'h00, 8'h00, 1'b1, 4'd8},
        '{32'h91A2_0000, 32'h0000_0000, 1'b1, 1'b1, 29'h1234_5678, 1'b1, 1'b0, 4'd0, 8'h00, 8'h00, 1'b1, 4'd8},
        '{32'h91A3_91A1, 32'h0000_0000, 1'b1, 1'b1, 29'h1234_5678, 1'b1, 1'b0, 4'd0, 8'h00, 8'h00, 1'b0, 4'd8},
        // R3 full mask accepts anything; single relevant bit decides
        '{32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, 29'h1FFF_FFFF, 1'b1, 1'b1, 4'd0, 8'h00, 8'h00, 1'b1, 4'd3},
        '{32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 1'b0, 29'h400, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00, 1'b1, 4'd3},
        '{32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 1'b0, 29'h3FF, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00, 1'b0, 4'd3}
    };

    task automatic chk(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: accept=%0b expected %0b", tag, act, exp);
        end
    endtask

    // Called at a falling edge; ends at the next falling edge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic frame(input logic [28:0] id, input logic ext, input logic rtr,
                         input logic [3:0] dlc, input logic [7:0] d0, input logic [7:0] d1);
        frm_id = id; frm_ext = ext; frm_rtr = rtr; frm_dlc = dlc;
        frm_data0 = d0; frm_data1 = d1; frm_valid = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R10: run did not finish, actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(accept, 1'b0, "R1 reset value");
        rst_n = 1'b1;
        @(negedge clk);

        // R1 default masks accept any frame
        frame(29'h000, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00);
        chk(accept, 1'b1, "R1 default accept legacy");

        // R2 writes ignored without cfg_hold
        cfg_hold = 1'b0;
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h01);
        frame(29'h000, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00);
        chk(accept, 1'b1, "R2 locked write ignored");

        // Table walk
        for (int v = 0; v < NV; v++) begin
            cfg_hold = 1'b1;
            for (int b = 0; b < 4; b++) begin
                wr(3'(b), VECS[v].code[(3-b)*8 +: 8]);
                wr(3'(b + 4), VECS[v].mask[(3-b)*8 +: 8]);
            end
            cfg_hold = 1'b0;
            enh_mode = VECS[v].enh;
            dual_flt = VECS[v].dual;
            frame(VECS[v].id, VECS[v].ext, VECS[v].rtr, VECS[v].dlc, VECS[v].d0, VECS[v].d1);
            chk(accept, VECS[v].exp, $sformatf("R%0d vector %0d", VECS[v].req, v));
        end

        // R11 write and strobe in the same cycle: old contents decide
        enh_mode = 1'b0; dual_flt = 1'b0;
        cfg_hold = 1'b1;
        wr(3'd0, 8'hA5);
        wr(3'd4, 8'h00);
        cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 8'h00;
        frame(29'h52F, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00);
        cfg_we = 1'b0;
        cfg_hold = 1'b0;
        chk(accept, 1'b1, "R11 same-cycle frame uses old code");
        frame(29'h52F, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00);
        chk(accept, 1'b0, "R11 following frame uses new code");

        // R10 verdict held while no strobe
        frame(29'h007, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00);
        chk(accept, 1'b1, "R10 match after strobe");
        frm_id = 29'h7FF;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(accept, 1'b1, "R10 held without strobe");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule